// File: doc/BRIEF.md
# Up-down PWM event flag and interrupt generator

This block watches a 16-bit up-down PWM counter and records the events that software needs to know about for one complementary output pair. The events are: the counter reaching zero, the counter reaching the period value, and a compare match. A compare match is filed under one of two flags, chosen by whether the counter was counting up or down when the match happened. A separate brake strobe from the brake logic sets a fifth flag. Every flag is sticky until software clears it by writing a one to its bit. The flags that software has enabled are ORed into one registered, level interrupt line.

Each event is detected on its rising condition. A counter that stays at zero, at the period value or at the compare value therefore sets its flag once, and does not set it again on every cycle it stays there. When the compare value equals zero or the period value, the point flag and the direction-dependent compare flag set together.

The block also applies output polarity to the two channel signals that come out of dead-time insertion. Each channel has its own invert bit, and the inversion is a pure combinational stage after dead time.

Top module: `pwm_evt_flags`

## Requirements
- R1: The zero flag is status bit 0. It sets at the first clock edge at which `cnt_i` equals 0 after not being 0 on the previous edge, and it is visible on `status_o` right after that edge.
- R2: The period flag is status bit 1. It sets at the first edge at which `cnt_i` equals `period_i`.
- R3: The compare-up flag is status bit 2. It sets at the first edge at which `cnt_i` equals `cmp_i` while `cnt_down_i` is 0 (counting up).
- R4: The compare-down flag is status bit 3. It sets at the first edge at which `cnt_i` equals `cmp_i` while `cnt_down_i` is 1 (counting down).
- R5: While a condition stays true on consecutive edges, its flag sets only on the first of those edges. After a clear it stays 0 while the counter holds.
- R6: A set flag stays set until a clear strobe is seen at an edge. `clr_i` bit k clears status bit k for k = 0..3, and `clr_i` bit 4 clears the brake flag. Clear bits for flags that are already 0 have no effect.
- R7: When a set event and a clear strobe for the same flag arrive at the same edge, the flag ends up set.
- R8: `brake_flag_o` sets at every edge at which `brake_evt_i` is 1.
- R9: `irq_o` is the OR of every flag that is set and enabled, registered, so it follows the flags one cycle later. `irq_en_i` bits 0..3 enable status bits 0..3, and bit 4 enables the brake flag. A set flag that is not enabled does not raise `irq_o`.
- R10: `ch0_o` is `ch0_dt_i` inverted when `pol_inv_i[0]` is 1, and `ch1_o` is `ch1_dt_i` inverted when `pol_inv_i[1]` is 1. The two bits act independently, and there is no added latency.
- R11: When `cmp_i` equals 0 or `period_i`, the matching point flag and the direction-dependent compare flag set at the same edge.
- R12: While `rst` is high at a clock edge, all status bits, the brake flag and `irq_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Current counter value |
| cnt_down_i | input | 1 | Count direction, 1 = down |
| period_i | input | 16 | Period value |
| cmp_i | input | 16 | Compare value |
| brake_evt_i | input | 1 | Brake event strobe |
| irq_en_i | input | 5 | Interrupt enables: bits 0..3 for status, bit 4 for brake |
| clr_i | input | 5 | Write-one-to-clear strobes, same bit map as irq_en_i |
| pol_inv_i | input | 2 | Per-channel output invert |
| ch0_dt_i | input | 1 | Channel 0 after dead-time insertion |
| ch1_dt_i | input | 1 | Channel 1 after dead-time insertion |
| status_o | output | 4 | Sticky flags: zero, period, compare-up, compare-down |
| brake_flag_o | output | 1 | Sticky brake flag |
| irq_o | output | 1 | Level interrupt |
| ch0_o | output | 1 | Channel 0 after polarity |
| ch1_o | output | 1 | Channel 1 after polarity |

## Verification
The bench holds the counter at zero and at the compare value across several edges, and clears in between. A design that uses the level rather than the rising condition would set the flag again at once. It also lets the counter pass the compare value in both directions. A design that ignores the direction would set the wrong compare flag or both. Clear and set are made to arrive on the same edge for both a status bit and the brake flag, and a design that gives the clear priority would lose that event. The interrupt is sampled one cycle after a flag rises, with enables both on and off, to catch a combinational or wrongly gated line. The compare value is also placed on zero and on the period value, to show that the two flags set together.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

    localparam int CNT_W   = 16;
    localparam int NUM_ST  = 4;
    localparam int NUM_EVT = NUM_ST + 1;
    localparam int NUM_CH  = 2;

    typedef enum int {
        EV_ZERO   = 0,
        EV_PERIOD = 1,
        EV_CMP_UP = 2,
        EV_CMP_DN = 3,
        EV_BRAKE  = 4
    } evt_idx_e;

    typedef struct packed {
        logic brake;
        logic cmp_dn;
        logic cmp_up;
        logic period;
        logic zero;
    } evt_vec_t;

    function automatic logic [NUM_ST-1:0] point_conds(
        input logic [CNT_W-1:0] cnt,
        input logic             down,
        input logic [CNT_W-1:0] per,
        input logic [CNT_W-1:0] cmpv
    );
        logic [NUM_ST-1:0] c;
        logic              hit;
        hit                = (cnt == cmpv);
        c[EV_ZERO]         = (cnt == '0);
        c[EV_PERIOD]       = (cnt == per);
        c[EV_CMP_UP]       = hit & ~down;
        c[EV_CMP_DN]       = hit & down;
        return c;
    endfunction

endpackage

// File: rtl/pwm_evt_edge.sv
module pwm_evt_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cond_i;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_rise
            assign rise_o[g] = cond_i[g] & ~prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/pwm_flag_bank.sv
module pwm_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    logic [N-1:0] flag_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)           flag_q[g] <= 1'b0;
                else if (set_i[g]) flag_q[g] <= 1'b1;
                else if (clr_i[g]) flag_q[g] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(flag_q & en_i);
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/pwm_pol_out.sv
module pwm_pol_out #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] dt_i,
    input  logic [NCH-1:0] inv_i,
    output logic [NCH-1:0] out_o
);
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign out_o[g] = inv_i[g] ? ~dt_i[g] : dt_i[g];
        end
    endgenerate
endmodule

// File: rtl/pwm_evt_flags.sv
module pwm_evt_flags
    import pwm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             brake_evt_i,
    input  logic [4:0]       irq_en_i,
    input  logic [4:0]       clr_i,
    input  logic [1:0]       pol_inv_i,
    input  logic             ch0_dt_i,
    input  logic             ch1_dt_i,
    output logic [3:0]       status_o,
    output logic             brake_flag_o,
    output logic             irq_o,
    output logic             ch0_o,
    output logic             ch1_o
);
    logic [NUM_ST-1:0] conds;
    logic [NUM_ST-1:0] rises;
    evt_vec_t          set_vec;
    evt_vec_t          flags;
    logic [NUM_CH-1:0] pol_out;

    assign conds = point_conds(cnt_i, cnt_down_i, period_i, cmp_i);

    pwm_evt_edge #(.N(NUM_ST)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .cond_i (conds),
        .rise_o (rises)
    );

    always_comb begin
        set_vec        = '0;
        set_vec.zero   = rises[EV_ZERO];
        set_vec.period = rises[EV_PERIOD];
        set_vec.cmp_up = rises[EV_CMP_UP];
        set_vec.cmp_dn = rises[EV_CMP_DN];
        set_vec.brake  = brake_evt_i;
    end

    pwm_flag_bank #(.N(NUM_EVT)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (clr_i),
        .en_i    (irq_en_i),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    assign status_o     = {flags.cmp_dn, flags.cmp_up, flags.period, flags.zero};
    assign brake_flag_o = flags.brake;

    pwm_pol_out #(.NCH(NUM_CH)) u_pol (
        .dt_i  ({ch1_dt_i, ch0_dt_i}),
        .inv_i (pol_inv_i),
        .out_o (pol_out)
    );

    assign ch0_o = pol_out[0];
    assign ch1_o = pol_out[1];
endmodule

// File: rtl/pwm_evt_flags_chk.sv
module pwm_evt_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cnt_i,
    input logic        cnt_down_i,
    input logic [15:0] cmp_i,
    input logic        brake_evt_i,
    input logic [4:0]  irq_en_i,
    input logic [4:0]  clr_i,
    input logic [3:0]  status_o,
    input logic        brake_flag_o,
    input logic        irq_o
);
    assert_zero_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_i == 16'd0 && $past(cnt_i) != 16'd0) |=> status_o[0]);

    assert_cmp_up_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_i == cmp_i && !cnt_down_i &&
         !($past(cnt_i) == $past(cmp_i) && !$past(cnt_down_i))) |=> status_o[2]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && !clr_i[0]) |=> status_o[0]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && clr_i[0] && cnt_i != 16'd0) |=> !status_o[0]);

    assert_brake_set_R8: assert property (@(posedge clk) disable iff (rst)
        brake_evt_i |=> brake_flag_o);

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|({brake_flag_o, status_o} & irq_en_i)));
endmodule

bind pwm_evt_flags pwm_evt_flags_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_i        (cnt_i),
    .cnt_down_i   (cnt_down_i),
    .cmp_i        (cmp_i),
    .brake_evt_i  (brake_evt_i),
    .irq_en_i     (irq_en_i),
    .clr_i        (clr_i),
    .status_o     (status_o),
    .brake_flag_o (brake_flag_o),
    .irq_o        (irq_o)
);

// File: tb/test_pwm_evt_flags.sv
`timescale 1ns/1ps
module test_pwm_evt_flags;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_i = 16'd5;
    logic        cnt_down_i = 1'b0;
    logic [15:0] period_i = 16'd100;
    logic [15:0] cmp_i = 16'd40;
    logic        brake_evt_i = 1'b0;
    logic [4:0]  irq_en_i = 5'd0;
    logic [4:0]  clr_i = 5'd0;
    logic [1:0]  pol_inv_i = 2'd0;
    logic        ch0_dt_i = 1'b0;
    logic        ch1_dt_i = 1'b0;
    logic [3:0]  status_o;
    logic        brake_flag_o, irq_o, ch0_o, ch1_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwm_evt_flags i_pwm_evt_flags (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
        .period_i(period_i), .cmp_i(cmp_i), .brake_evt_i(brake_evt_i),
        .irq_en_i(irq_en_i), .clr_i(clr_i), .pol_inv_i(pol_inv_i),
        .ch0_dt_i(ch0_dt_i), .ch1_dt_i(ch1_dt_i), .status_o(status_o),
        .brake_flag_o(brake_flag_o), .irq_o(irq_o), .ch0_o(ch0_o), .ch1_o(ch1_o)
    );

    // cnt, down, clr, brake, expected status, expected brake flag (period 100, compare 40)
    typedef struct packed {
        logic [15:0] cnt;
        logic        dn;
        logic [4:0]  clr;
        logic        brk;
        logic [3:0]  st;
        logic        bf;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{16'd5,   1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0},
        '{16'd0,   1'b0, 5'b00000, 1'b0, 4'b0001, 1'b0}, // R1
        '{16'd0,   1'b0, 5'b00001, 1'b0, 4'b0000, 1'b0}, // R5 R6
        '{16'd0,   1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0}, // R5
        '{16'd40,  1'b0, 5'b00000, 1'b0, 4'b0100, 1'b0}, // R3
        '{16'd40,  1'b0, 5'b00000, 1'b0, 4'b0100, 1'b0},
        '{16'd100, 1'b0, 5'b00000, 1'b0, 4'b0110, 1'b0}, // R2
        '{16'd40,  1'b1, 5'b00000, 1'b0, 4'b1110, 1'b0}, // R4
        '{16'd41,  1'b1, 5'b00110, 1'b0, 4'b1000, 1'b0}, // R6
        '{16'd40,  1'b1, 5'b01000, 1'b0, 4'b1000, 1'b0}, // R7
        '{16'd10,  1'b1, 5'b01000, 1'b0, 4'b0000, 1'b0},
        '{16'd10,  1'b0, 5'b00000, 1'b1, 4'b0000, 1'b1}, // R8
        '{16'd10,  1'b0, 5'b10000, 1'b0, 4'b0000, 1'b0},
        '{16'd10,  1'b0, 5'b10000, 1'b1, 4'b0000, 1'b1}, // R7 R8
        '{16'd10,  1'b0, 5'b11111, 1'b0, 4'b0000, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [15:0] c, input logic d, input logic [4:0] cl, input logic b);
        @(negedge clk);
        cnt_i = c; cnt_down_i = d; clr_i = cl; brake_evt_i = b;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0;
        check("R12 reset status", {4'd0, status_o}, 8'd0);
        check("R12 reset brake/irq", {6'd0, brake_flag_o, irq_o}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cnt, VECS[i].dn, VECS[i].clr, VECS[i].brk);
            step();
            check($sformatf("R1-table vec%0d status", i), {4'd0, status_o}, {4'd0, VECS[i].st});
            check($sformatf("R8 table vec%0d brake", i), {7'd0, brake_flag_o}, {7'd0, VECS[i].bf});
        end

        // R9: one-cycle lag and enable gating
        @(negedge clk); irq_en_i = 5'b00001; clr_i = 5'd0;
        drive(16'd0, 1'b0, 5'd0, 1'b0);
        step();
        check("R9 flag up, irq not yet", {6'd0, status_o[0], irq_o}, 8'b10);
        step();
        check("R9 irq after one cycle", {7'd0, irq_o}, 8'd1);
        @(negedge clk); irq_en_i = 5'b00000;
        step();
        check("R9 irq drops when disabled", {7'd0, irq_o}, 8'd0);
        drive(16'd10, 1'b0, 5'b00001, 1'b1);
        step(); step();
        check("R9 disabled brake no irq", {6'd0, brake_flag_o, irq_o}, 8'b10);
        @(negedge clk); irq_en_i = 5'b10000; brake_evt_i = 1'b0; clr_i = 5'd0;
        step(); step();
        check("R9 brake enable irq", {7'd0, irq_o}, 8'd1);
        @(negedge clk); irq_en_i = 5'd0; clr_i = 5'b11111;
        step(); step();
        check("R9 irq after clear", {6'd0, brake_flag_o, irq_o}, 8'd0);

        // R10 polarity, all combinations
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 4; d++) begin
                @(negedge clk);
                clr_i = 5'd0;
                pol_inv_i = p[1:0]; ch0_dt_i = d[0]; ch1_dt_i = d[1];
                #1;
                check($sformatf("R10 pol=%0d dt=%0d", p, d), {6'd0, ch1_o, ch0_o},
                      {6'd0, d[1] ^ p[1], d[0] ^ p[0]});
            end
        end

        // R11: compare equal to zero, then to period
        @(negedge clk); cmp_i = 16'd0; clr_i = 5'd0;
        drive(16'd7, 1'b1, 5'd0, 1'b0); step();
        drive(16'd0, 1'b1, 5'd0, 1'b0); step();
        check("R11 cmp=0 down", {4'd0, status_o}, 8'b1001);
        @(negedge clk); cmp_i = 16'd100;
        drive(16'd99, 1'b0, 5'b01111, 1'b0); step();
        drive(16'd100, 1'b0, 5'd0, 1'b0); step();
        check("R11 cmp=period up", {4'd0, status_o}, 8'b0110);

        // R12: reset mid-run
        @(negedge clk); brake_evt_i = 1'b1; irq_en_i = 5'b11111;
        step(); step();
        @(negedge clk); rst = 1'b1; brake_evt_i = 1'b0;
        step();
        check("R12 mid-run reset", {2'd0, status_o, brake_flag_o, irq_o}, 8'd0);
        @(negedge clk); rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule